// File: doc/BRIEF.md
# DDR Read Burst Data Path

This block is the device-side read data path of a double-data-rate SDRAM, modelled at single-clock level. Each clock cycle carries two data words, one for the rising half and one for the falling half. A command port takes READ, BURST TERMINATE and NOP codes together with a bank and a start column. For every READ the block sends a burst of data-word pairs. The first pair appears a fixed CAS latency after the command, and the pairs follow one per cycle. A strobe-enable output opens one cycle ahead of the data as a read preamble.

The burst length is chosen per READ: 2, 4, 8 or 16 elements. Column addresses inside a burst count up from the start column and wrap within the block aligned to the burst length. A newer READ cuts off a running burst, and its pairs follow with no gap. A BURST TERMINATE stops the output with the same latency as a READ. Data comes from a deterministic pattern of bank and column, so the surrounding memory-model or controller test can predict every word.

Top module: `ddrrd_path`

## Requirements
- R1: While rst_ni is low, and after reset until a READ reaches the output, dq_valid_o and dqs_en_o are low; a READ presented during reset produces no data.
- R2: A READ (cmd_i = 2'b01) accepted in cycle t puts its first pair on the outputs in cycle t+CAS_LAT, with dq_valid_o high.
- R3: bl_code_i values 0, 1, 2, 3 select bursts of 2, 4, 8, 16 elements; an uninterrupted burst sends exactly half that many pairs in consecutive cycles, then dq_valid_o falls.
- R4: Element j of a burst of length BL starting at column S addresses column (S & ~(BL-1)) | ((S+j) & (BL-1)); pair k carries element 2k on dq_rise_o and element 2k+1 on dq_fall_o.
- R5: The word for bank B and column C is the low DATA_W bits of ({B, C} * PAT_MUL) XOR PAT_XOR (defaults 16'h9E37 and 16'hA5C3).
- R6: A READ accepted while an earlier burst is still being sent interrupts it: from cycle t+CAS_LAT on, only the new burst appears, with no idle cycle in between.
- R7: READs accepted on consecutive cycles each give their pairs in turn, one pair per cycle, with no gap.
- R8: A BURST TERMINATE (cmd_i = 2'b10) accepted in cycle t leaves all pairs due before cycle t+CAS_LAT untouched and removes every pair from cycle t+CAS_LAT on.
- R9: NOP (2'b00) and the reserved code 2'b11 do not disturb a running burst, and a BURST TERMINATE with no burst running has no effect on the outputs.
- R10: dqs_en_o is high exactly in the cycles where dq_valid_o is high and in the cycle just before each one (read preamble).
- R11: The burst length and bank are taken when the READ is accepted; later changes of bl_code_i or bank_i do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 00 NOP, 01 READ, 10 BURST TERMINATE, 11 reserved (NOP) |
| bank_i | input | BANK_W | Bank of a READ |
| col_i | input | COL_W | Start column of a READ |
| bl_code_i | input | 2 | Burst length select of a READ (2 << code elements) |
| dq_rise_o | output | DATA_W | Word for the rising half of the cycle |
| dq_fall_o | output | DATA_W | Word for the falling half of the cycle |
| dq_valid_o | output | 1 | A data pair is on the bus this cycle |
| dqs_en_o | output | 1 | Strobe enable, including one preamble cycle |

## Verification
A command accepted in cycle t first affects the data outputs in cycle t+CAS_LAT. The strobe enable is already due one cycle earlier, in t+CAS_LAT-1. The bench drives commands on the falling edge. Each command writes its expected pairs into a per-cycle table starting at index t+CAS_LAT; a READ or terminate first clears that part of the table. The bench compares the outputs with the entry for the current cycle at the next falling edge. The strobe check reads the current entry and the next one. This is safe because no later command can still change those two entries.

// File: rtl/ddrrd_pkg.sv
package ddrrd_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_READ = 2'b01,
      CMD_BST  = 2'b10,
      CMD_RSVD = 2'b11
   } ddrrd_cmd_e;

   // longest burst is 16 elements, i.e. 8 pairs
   localparam int unsigned MAX_PAIRS = 8;
   localparam int unsigned PAIR_W    = $clog2(MAX_PAIRS);
   localparam int unsigned BLC_W     = 2;

   function automatic logic [PAIR_W:0] pair_count(input logic [BLC_W-1:0] code);
      return (PAIR_W+1)'(1) << code;
   endfunction

endpackage

// File: rtl/ddrrd_burst_gen.sv
module ddrrd_burst_gen
   import ddrrd_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned COL_W  = 10
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  ddrrd_cmd_e         cmd_i,
   input  logic [BANK_W-1:0]  bank_i,
   input  logic [COL_W-1:0]   col_i,
   input  logic [BLC_W-1:0]   bl_code_i,
   output logic               ent_valid_o,
   output logic [BANK_W-1:0]  ent_bank_o,
   output logic [COL_W-1:0]   ent_col_o,
   output logic [PAIR_W-1:0]  ent_idx_o,
   output logic [BLC_W-1:0]   ent_bl_o
);

   logic              act_q,  act_d;
   logic [BANK_W-1:0] bank_q, bank_d;
   logic [COL_W-1:0]  col_q,  col_d;
   logic [PAIR_W-1:0] idx_q,  idx_d;
   logic [BLC_W-1:0]  bl_q,   bl_d;

   always_comb begin
      act_d       = act_q;
      bank_d      = bank_q;
      col_d       = col_q;
      idx_d       = idx_q;
      bl_d        = bl_q;
      ent_valid_o = 1'b0;
      ent_bank_o  = bank_q;
      ent_col_o   = col_q;
      ent_idx_o   = idx_q;
      ent_bl_o    = bl_q;
      unique case (cmd_i)
         CMD_READ: begin
            ent_valid_o = 1'b1;
            ent_bank_o  = bank_i;
            ent_col_o   = col_i;
            ent_idx_o   = '0;
            ent_bl_o    = bl_code_i;
            bank_d      = bank_i;
            col_d       = col_i;
            bl_d        = bl_code_i;
            idx_d       = PAIR_W'(1);
            act_d       = (bl_code_i != '0);
         end
         CMD_BST: begin
            act_d = 1'b0;
         end
         default: begin
            if (act_q) begin
               ent_valid_o = 1'b1;
               idx_d       = idx_q + PAIR_W'(1);
               if (({1'b0, idx_q} + (PAIR_W+1)'(1)) == pair_count(bl_q)) begin
                  act_d = 1'b0;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q  <= 1'b0;
         bank_q <= '0;
         col_q  <= '0;
         idx_q  <= '0;
         bl_q   <= '0;
      end else begin
         act_q  <= act_d;
         bank_q <= bank_d;
         col_q  <= col_d;
         idx_q  <= idx_d;
         bl_q   <= bl_d;
      end
   end

endmodule

// File: rtl/ddrrd_lat_pipe.sv
module ddrrd_lat_pipe #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         in_valid_i,
   input  logic [W-1:0] in_data_i,
   output logic         out_valid_o,
   output logic [W-1:0] out_data_o,
   output logic         next_valid_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ddrrd_lat_pipe: DEPTH must be at least 2");
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic [W:0] st_q;
      logic [W:0] st_d;
      if (s == 0) begin : g_head
         assign st_d = {in_valid_i, in_data_i};
      end else begin : g_body
         assign st_d = g_stage[s-1].st_q;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) st_q <= '0;
         else         st_q <= st_d;
      end
   end

   assign out_valid_o  = g_stage[DEPTH-1].st_q[W];
   assign out_data_o   = g_stage[DEPTH-1].st_q[W-1:0];
   assign next_valid_o = g_stage[DEPTH-2].st_q[W];

endmodule

// File: rtl/ddrrd_pattern.sv
module ddrrd_pattern
   import ddrrd_pkg::*;
#(
   parameter int unsigned       BANK_W    = 2,
   parameter int unsigned       COL_W     = 10,
   parameter int unsigned       DATA_W    = 16,
   parameter logic [DATA_W-1:0] PAT_MUL   = 16'h9E37,
   parameter logic [DATA_W-1:0] PAT_XOR   = 16'hA5C3,
   parameter bit                ZERO_IDLE = 1'b1
) (
   input  logic                 valid_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic [COL_W-1:0]     col_i,
   input  logic [PAIR_W-1:0]    idx_i,
   input  logic [BLC_W-1:0]     bl_i,
   output logic [1:0][DATA_W-1:0] word_o
);

   localparam int unsigned KEY_W = BANK_W + COL_W;

   if (KEY_W > DATA_W) begin : g_bad_key
      $error("ddrrd_pattern: bank and column must fit in DATA_W");
   end
   if (COL_W < 4) begin : g_bad_col
      $error("ddrrd_pattern: COL_W must cover a 16-element burst");
   end

   logic [COL_W-1:0] mask;
   assign mask = COL_W'((5'd2 << bl_i) - 5'd1);

   for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      logic [COL_W-1:0]  off;
      logic [COL_W-1:0]  ecol;
      logic [DATA_W-1:0] key;
      logic [DATA_W-1:0] raw;
      assign off  = COL_W'({idx_i, 1'(ln)});
      assign ecol = (col_i & ~mask) | ((col_i + off) & mask);
      assign key  = DATA_W'({bank_i, ecol});
      assign raw  = (key * PAT_MUL) ^ PAT_XOR;
      if (ZERO_IDLE) begin : g_gate
         assign word_o[ln] = valid_i ? raw : '0;
      end else begin : g_pass
         assign word_o[ln] = raw;
      end
   end

endmodule

// File: rtl/ddrrd_path.sv
module ddrrd_path
   import ddrrd_pkg::*;
#(
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       BANK_W    = 2,
   parameter int unsigned       COL_W     = 10,
   parameter int unsigned       CAS_LAT   = 3,
   parameter logic [DATA_W-1:0] PAT_MUL   = 16'h9E37,
   parameter logic [DATA_W-1:0] PAT_XOR   = 16'hA5C3,
   parameter bit                ZERO_IDLE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [1:0]        bl_code_i,
   output logic [DATA_W-1:0] dq_rise_o,
   output logic [DATA_W-1:0] dq_fall_o,
   output logic              dq_valid_o,
   output logic              dqs_en_o
);

   localparam int unsigned ENT_W = BANK_W + COL_W + PAIR_W + BLC_W;

   if (CAS_LAT < 2) begin : g_bad_lat
      $error("ddrrd_path: CAS_LAT must be at least 2 for the preamble");
   end
   if (PAT_MUL[0] != 1'b1) begin : g_bad_mul
      $error("ddrrd_path: PAT_MUL must be odd");
   end

   logic              ent_v;
   logic [BANK_W-1:0] ent_bank;
   logic [COL_W-1:0]  ent_col;
   logic [PAIR_W-1:0] ent_idx;
   logic [BLC_W-1:0]  ent_bl;
   logic [ENT_W-1:0]  ent_vec;

   logic              out_v;
   logic              nxt_v;
   logic [ENT_W-1:0]  out_vec;
   logic [1:0][DATA_W-1:0] words;

   ddrrd_burst_gen #(
      .BANK_W (BANK_W),
      .COL_W  (COL_W)
   ) gen_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (ddrrd_cmd_e'(cmd_i)),
      .bank_i      (bank_i),
      .col_i       (col_i),
      .bl_code_i   (bl_code_i),
      .ent_valid_o (ent_v),
      .ent_bank_o  (ent_bank),
      .ent_col_o   (ent_col),
      .ent_idx_o   (ent_idx),
      .ent_bl_o    (ent_bl)
   );

   assign ent_vec = {ent_bank, ent_col, ent_idx, ent_bl};

   ddrrd_lat_pipe #(
      .W     (ENT_W),
      .DEPTH (CAS_LAT)
   ) pipe_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .in_valid_i   (ent_v),
      .in_data_i    (ent_vec),
      .out_valid_o  (out_v),
      .out_data_o   (out_vec),
      .next_valid_o (nxt_v)
   );

   ddrrd_pattern #(
      .BANK_W    (BANK_W),
      .COL_W     (COL_W),
      .DATA_W    (DATA_W),
      .PAT_MUL   (PAT_MUL),
      .PAT_XOR   (PAT_XOR),
      .ZERO_IDLE (ZERO_IDLE)
   ) pat_i (
      .valid_i (out_v),
      .bank_i  (out_vec[ENT_W-1 -: BANK_W]),
      .col_i   (out_vec[PAIR_W+BLC_W +: COL_W]),
      .idx_i   (out_vec[BLC_W +: PAIR_W]),
      .bl_i    (out_vec[BLC_W-1:0]),
      .word_o  (words)
   );

   assign dq_rise_o  = words[0];
   assign dq_fall_o  = words[1];
   assign dq_valid_o = out_v;
   assign dqs_en_o   = out_v | nxt_v;

endmodule

// File: rtl/ddrrd_path_chk.sv
module ddrrd_path_chk #(
   parameter int unsigned CAS_LAT = 3
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] cmd_i,
   input logic       dq_valid_o,
   input logic       dqs_en_o
);

   logic [CAS_LAT-1:0] rd_hist;
   logic [CAS_LAT-1:0] bst_hist;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_hist  <= '0;
         bst_hist <= '0;
      end else begin
         rd_hist  <= {rd_hist[CAS_LAT-2:0],  cmd_i == 2'b01};
         bst_hist <= {bst_hist[CAS_LAT-2:0], cmd_i == 2'b10};
      end
   end

   // R2
   read_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_hist[CAS_LAT-1] |-> dq_valid_o);

   // R8
   bst_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bst_hist[CAS_LAT-1] |-> !dq_valid_o);

   // R10
   strobe_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dq_valid_o |-> dqs_en_o);

   // R10
   preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dq_valid_o) |-> $past(dqs_en_o));

   // R1
   idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_hist == '0 && !dq_valid_o && $past(!dq_valid_o)) |-> !dqs_en_o);

endmodule

bind ddrrd_path ddrrd_path_chk #(.CAS_LAT(CAS_LAT)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cmd_i      (cmd_i),
   .dq_valid_o (dq_valid_o),
   .dqs_en_o   (dqs_en_o)
);

// File: tb/ddrrd_path_tb_top.sv
module ddrrd_path_tb_top;

   localparam int unsigned DW = 16;
   localparam int unsigned BW = 2;
   localparam int unsigned CW = 10;
   localparam int unsigned CL = 3;
   localparam logic [DW-1:0] MUL = 16'h9E37;
   localparam logic [DW-1:0] XR  = 16'hA5C3;
   localparam int unsigned NSLOT = 4096;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic [1:0]    cmd;
   logic [BW-1:0] bank;
   logic [CW-1:0] col;
   logic [1:0]    blc;
   logic [DW-1:0] dq_r, dq_f;
   logic          dq_v, dqs;

   ddrrd_path dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .col_i(col),
      .bl_code_i(blc), .dq_rise_o(dq_r), .dq_fall_o(dq_f),
      .dq_valid_o(dq_v), .dqs_en_o(dqs)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   string cur_req = "R1";

   bit            exp_v [NSLOT];
   logic [DW-1:0] exp_r [NSLOT];
   logic [DW-1:0] exp_f [NSLOT];

   function automatic logic [DW-1:0] word_of(input logic [BW-1:0] b, input logic [CW-1:0] c);
      logic [DW-1:0] k;
      k = DW'({b, c});
      return (k * MUL) ^ XR;
   endfunction

   function automatic logic [CW-1:0] col_of(input logic [CW-1:0] s, input logic [1:0] code, input int j);
      logic [CW-1:0] m;
      m = CW'((2 << code) - 1);
      return (s & ~m) | ((s + CW'(j)) & m);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s cycle %0d actual=%h expected=%h", req, what, cyc, act, exp);
      end
   endtask

   // one cycle: check current outputs, schedule and drive this cycle's command
   task automatic step(input logic [1:0] c, input logic [BW-1:0] b,
                       input logic [CW-1:0] co, input logic [1:0] bl);
      check(dq_v == exp_v[cyc], cur_req, "dq_valid", 32'(dq_v), 32'(exp_v[cyc]));
      if (exp_v[cyc]) begin
         check(dq_r == exp_r[cyc], cur_req, "dq_rise", 32'(dq_r), 32'(exp_r[cyc]));
         check(dq_f == exp_f[cyc], cur_req, "dq_fall", 32'(dq_f), 32'(exp_f[cyc]));
      end
      check(dqs == (exp_v[cyc] | exp_v[cyc+1]), "R10", "dqs_en", 32'(dqs),
            32'(exp_v[cyc] | exp_v[cyc+1]));
      if (c == 2'b01 || c == 2'b10) begin
         for (int i = 0; i <= 8; i++) exp_v[cyc+CL+i] = 1'b0;
      end
      if (c == 2'b01) begin
         for (int k = 0; k < (1 << bl); k++) begin
            exp_v[cyc+CL+k] = 1'b1;
            exp_r[cyc+CL+k] = word_of(b, col_of(co, bl, 2*k));
            exp_f[cyc+CL+k] = word_of(b, col_of(co, bl, 2*k+1));
         end
      end
      cmd = c; bank = b; col = co; blc = bl;
      @(negedge clk);
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(2'b00, BW'(i), CW'(i * 37), 2'(i));
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog run did not finish, actual cycles=%0d expected below 200000", cyc);
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd = 2'b01; bank = '0; col = '0; blc = 2'd3;
      // R1: reset holds outputs low even with a READ on the command port
      repeat (4) begin
         @(negedge clk);
         check(dq_v == 1'b0, "R1", "dq_valid in reset", 32'(dq_v), 32'd0);
         check(dqs == 1'b0, "R1", "dqs_en in reset", 32'(dqs), 32'd0);
      end
      cmd = 2'b00;
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      idle(6);

      cur_req = "R2";
      step(2'b01, 2'd1, 10'h010, 2'd1); idle(6);

      cur_req = "R3";
      for (int code = 0; code < 4; code++) begin
         step(2'b01, 2'd2, 10'h020, 2'(code)); idle(12);
      end

      cur_req = "R4";
      step(2'b01, 2'd0, 10'h01D, 2'd2); idle(8);
      step(2'b01, 2'd3, 10'h3FE, 2'd3); idle(12);
      step(2'b01, 2'd1, 10'h107, 2'd1); idle(6);

      cur_req = "R5";
      step(2'b01, 2'd3, 10'h155, 2'd0); idle(2);
      step(2'b01, 2'd0, 10'h2AA, 2'd0); idle(5);

      cur_req = "R6";
      step(2'b01, 2'd0, 10'h040, 2'd3); idle(2);
      step(2'b01, 2'd1, 10'h080, 2'd2); idle(10);

      cur_req = "R7";
      for (int i = 0; i < 6; i++) step(2'b01, 2'(i), CW'(10'h100 + 2*i), 2'd0);
      for (int i = 0; i < 4; i++) step(2'b01, 2'(i), CW'(10'h200 + 4*i), 2'd1);
      idle(8);

      cur_req = "R8";
      step(2'b01, 2'd2, 10'h060, 2'd3); idle(2);
      step(2'b10, 2'd0, 10'h000, 2'd0); idle(10);
      step(2'b01, 2'd1, 10'h070, 2'd2);
      step(2'b10, 2'd0, 10'h000, 2'd0); idle(8);

      cur_req = "R9";
      step(2'b10, 2'd0, 10'h000, 2'd0);
      step(2'b11, 2'd1, 10'h123, 2'd3); idle(6);
      step(2'b01, 2'd3, 10'h090, 2'd3);
      for (int i = 0; i < 7; i++) step(2'b11, 2'd0, 10'h000, 2'd0);
      idle(6);

      cur_req = "R11";
      step(2'b01, 2'd2, 10'h0A4, 2'd1);
      for (int i = 0; i < 8; i++) step(2'b00, 2'd3, 10'h3FF, 2'd3);

      cur_req = "R6";
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3000; i++) begin
         int sel;
         logic [1:0] c;
         sel = int'($urandom % 100);
         if (sel < 45)      c = 2'b00;
         else if (sel < 78) c = 2'b01;
         else if (sel < 90) c = 2'b10;
         else               c = 2'b11;
         step(c, BW'($urandom), CW'($urandom), 2'($urandom));
      end
      idle(16);

      summary();
      $finish;
   end

endmodule